// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Enable Control

This block owns the eight-bit status register of a small serial NOR flash and decides whether each memory write command may proceed. A serial front end decodes the incoming opcodes and delivers them as single-cycle pulses. These pulses are write enable, write disable, status write (with its data byte), byte-program start, erase start and auto-increment program start. The program/erase engine returns completion pulses together with the address it last programmed. The block tracks the busy flag, the write-enable latch, two block-protect bits, the auto-increment mode flag and the protect-lock bit. It also presents the register byte for status reads.

Every memory write command gets a registered verdict one cycle after its pulse. A go verdict starts the internal operation. A reject verdict means the command had no effect. While an operation runs, commands get no verdict at all. The write-enable latch clears itself when an operation completes or when a write disable arrives, so each program or erase must be preceded by a fresh write enable. Auto-increment programming is the exception: the latch stays set across its bytes until the mode ends. The front end presents at most one command pulse per cycle.

Top module: `flash_status_ctl`

## Requirements
- R1: The synchronous reset leaves the status byte at 0x0C and both verdict outputs low. That value means both protect bits are 1 and all other bits are 0.
- R2: The status byte layout is: bit 0 busy, bit 1 write-enable latch, bit 2 protect bit 0, bit 3 protect bit 1, bit 6 auto-increment mode, bit 7 protect lock. Bits 4 and 5 always read 0.
- R3: A write enable pulse received while not busy sets the write-enable latch in the following cycle.
- R4: A write disable pulse received while not busy clears the write-enable latch and the auto-increment mode bit in the following cycle.
- R5: A program, erase or auto-increment start received while not busy and with the latch set gives `cmd_go` for one cycle, in the cycle after the pulse, and busy rises in that same cycle. With the latch clear, the same command gives `cmd_reject` instead and changes no status bit.
- R6: While busy is 1, every command pulse is ignored. It produces no verdict and changes no status bit.
- R7: A program or erase completion pulse while busy clears busy in the next cycle. It also clears the write-enable latch, unless auto-increment mode is active and the address given is not the array's last address.
- R8: A status write is accepted only when the latch is set and busy is 0. When accepted, bit 7 of the data loads the lock. Data bits 3:2 load the protect bits only if the lock was 0 before the write. Busy, the latch and the mode bit ignore the written data, and an accepted status write does not clear the latch.
- R9: An accepted auto-increment start sets the mode bit and busy together. While the mode bit is 1, a program start continues the sequence with a go verdict, and an erase start or another auto-increment start is rejected.
- R10: A completion in auto-increment mode whose address equals `ADDR_MAX` clears both the write-enable latch and the mode bit in the next cycle.
- R11: `cmd_go` and `cmd_reject` are never high together, and neither is high unless a memory write command was presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_cmd | input | 1 | Write enable command pulse |
| wrdi_cmd | input | 1 | Write disable command pulse |
| wrsr_cmd | input | 1 | Status write command pulse |
| wrsr_data | input | 8 | Data byte of the status write |
| prog_start | input | 1 | Byte program (or next auto-increment byte) start pulse |
| prog_done | input | 1 | Program completion pulse from the engine |
| erase_start | input | 1 | Erase start pulse (sector, block or chip) |
| erase_done | input | 1 | Erase completion pulse from the engine |
| aai_start | input | 1 | Auto-increment programming start pulse |
| prog_addr | input | ADDR_W | Address of the byte whose completion is signalled |
| status_byte | output | 8 | Current status register value |
| cmd_go | output | 1 | Registered accept verdict for a memory write command |
| cmd_reject | output | 1 | Registered reject verdict for a memory write command |

## Verification
Every result of this block is due exactly one clock after the pulse that causes it. This holds for status bits, verdicts and self-clearing alike, because each state bit and each verdict sits behind a single flop. The bench applies stimulus just after a falling edge. In the same step it advances a behavioural model to the state that should follow the next rising edge. It compares all three outputs at the falling edge after that, so every comparison lands one cycle after its cause. Commands held during a busy window are compared in every cycle, which shows that nothing moved.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  // Bit positions inside the status byte (decoded by the status read path)
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEL  = 1;
  localparam int unsigned ST_BP0  = 2;
  localparam int unsigned ST_BP1  = 3;
  localparam int unsigned ST_AAI  = 6;
  localparam int unsigned ST_LOCK = 7;
  localparam int unsigned ST_W    = 8;

  // Value of the protect pair after reset: whole array protected
  localparam logic [1:0] BP_RESET = 2'b11;

  // Decoded command pulses, one field per command
  typedef struct packed {
    logic wren;
    logic wrdi;
    logic wrsr;
    logic pgm;
    logic ers;
    logic aai;
  } cmd_t;

  typedef enum logic [1:0] {
    VERDICT_NONE   = 2'd0,
    VERDICT_GO     = 2'd1,
    VERDICT_REJECT = 2'd2
  } verdict_e;

endpackage

// File: rtl/fsc_gate.sv
module fsc_gate
  import fsc_pkg::*;
(
  input  cmd_t     cmd,
  input  logic     busy,
  input  logic     wel,
  input  logic     aai_mode,
  output cmd_t     acc,
  output verdict_e verdict
);

  logic idle;
  logic mem_req;
  logic mem_acc;

  assign idle = ~busy;

  always_comb begin
    acc      = '0;
    acc.wren = cmd.wren & idle;
    acc.wrdi = cmd.wrdi & idle;
    acc.wrsr = cmd.wrsr & idle & wel;
    acc.pgm  = cmd.pgm  & idle & wel;
    acc.ers  = cmd.ers  & idle & wel & ~aai_mode;
    acc.aai  = cmd.aai  & idle & wel & ~aai_mode;
  end

  assign mem_req = cmd.pgm | cmd.ers | cmd.aai;
  assign mem_acc = acc.pgm | acc.ers | acc.aai;

  always_comb begin
    if (!idle || !mem_req) begin
      verdict = VERDICT_NONE;
    end else if (mem_acc) begin
      verdict = VERDICT_GO;
    end else begin
      verdict = VERDICT_REJECT;
    end
  end

endmodule

// File: rtl/fsc_mode.sv
module fsc_mode
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_MAX = 32'h7FFFF,
  parameter int unsigned ADDR_W   = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_t              acc,
  input  logic              prog_done,
  input  logic              erase_done,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic              busy,
  output logic              aai_mode,
  output logic              op_done,
  output logic              end_hit
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ADDR_MAX);

  logic start_any;

  assign start_any = acc.pgm | acc.ers | acc.aai;
  assign op_done   = busy & (prog_done | erase_done);
  assign end_hit   = aai_mode & (prog_addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (op_done) begin
      busy <= 1'b0;
    end else if (start_any) begin
      busy <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aai_mode <= 1'b0;
    end else if (acc.wrdi) begin
      aai_mode <= 1'b0;
    end else if (op_done && end_hit) begin
      aai_mode <= 1'b0;
    end else if (acc.aai) begin
      aai_mode <= 1'b1;
    end
  end

endmodule

// File: rtl/fsc_wel.sv
module fsc_wel
  import fsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cmd_t acc,
  input  logic op_done,
  input  logic aai_mode,
  input  logic end_hit,
  output logic wel
);

  logic auto_clear;

  // Completion ends the write permission unless an auto-increment run continues
  assign auto_clear = op_done & (~aai_mode | end_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0;
    end else if (acc.wrdi || auto_clear) begin
      wel <= 1'b0;
    end else if (acc.wren) begin
      wel <= 1'b1;
    end
  end

endmodule

// File: rtl/fsc_prot.sv
module fsc_prot
  import fsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  cmd_t            acc,
  input  logic [ST_W-1:0] wr_data,
  output logic [1:0]      bp,
  output logic            lock
);

  logic unused_data_bits;
  assign unused_data_bits = ^{wr_data[ST_AAI], wr_data[5:4], wr_data[ST_WEL], wr_data[ST_BUSY]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lock <= 1'b0;
    end else if (acc.wrsr) begin
      lock <= wr_data[ST_LOCK];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp <= BP_RESET;
    end else if (acc.wrsr && !lock) begin
      bp <= {wr_data[ST_BP1], wr_data[ST_BP0]};
    end
  end

endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_MAX = 32'h7FFFF,
  localparam int unsigned ADDR_W  = $clog2(ADDR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wren_cmd,
  input  logic              wrdi_cmd,
  input  logic              wrsr_cmd,
  input  logic [7:0]        wrsr_data,
  input  logic              prog_start,
  input  logic              prog_done,
  input  logic              erase_start,
  input  logic              erase_done,
  input  logic              aai_start,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        status_byte,
  output logic              cmd_go,
  output logic              cmd_reject
);

  cmd_t     cmd;
  cmd_t     acc;
  verdict_e verdict;
  logic     busy;
  logic     wel;
  logic     aai_mode;
  logic     op_done;
  logic     end_hit;
  logic [1:0] bp;
  logic     lock;

  always_comb begin
    cmd      = '0;
    cmd.wren = wren_cmd;
    cmd.wrdi = wrdi_cmd;
    cmd.wrsr = wrsr_cmd;
    cmd.pgm  = prog_start;
    cmd.ers  = erase_start;
    cmd.aai  = aai_start;
  end

  fsc_gate u_gate (
    .cmd      (cmd),
    .busy     (busy),
    .wel      (wel),
    .aai_mode (aai_mode),
    .acc      (acc),
    .verdict  (verdict)
  );

  fsc_mode #(
    .ADDR_MAX (ADDR_MAX),
    .ADDR_W   (ADDR_W)
  ) u_mode (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .prog_done  (prog_done),
    .erase_done (erase_done),
    .prog_addr  (prog_addr),
    .busy       (busy),
    .aai_mode   (aai_mode),
    .op_done    (op_done),
    .end_hit    (end_hit)
  );

  fsc_wel u_wel (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .op_done  (op_done),
    .aai_mode (aai_mode),
    .end_hit  (end_hit),
    .wel      (wel)
  );

  fsc_prot u_prot (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .wr_data (wrsr_data),
    .bp      (bp),
    .lock    (lock)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_go     <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_go     <= (verdict == VERDICT_GO);
      cmd_reject <= (verdict == VERDICT_REJECT);
    end
  end

  always_comb begin
    status_byte          = '0;
    status_byte[ST_BUSY] = busy;
    status_byte[ST_WEL]  = wel;
    status_byte[ST_BP0]  = bp[0];
    status_byte[ST_BP1]  = bp[1];
    status_byte[ST_AAI]  = aai_mode;
    status_byte[ST_LOCK] = lock;
  end

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int unsigned ADDR_MAX = 32'h7FFFF,
  parameter int unsigned ADDR_W   = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              wren_cmd,
  input logic              wrdi_cmd,
  input logic              wrsr_cmd,
  input logic              prog_start,
  input logic              prog_done,
  input logic              erase_start,
  input logic              erase_done,
  input logic              aai_start,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [7:0]        status_byte,
  input logic              cmd_go,
  input logic              cmd_reject
);

  logic any_cmd;
  logic mem_cmd;
  assign any_cmd = wren_cmd | wrdi_cmd | wrsr_cmd | prog_start | erase_start | aai_start;
  assign mem_cmd = prog_start | erase_start | aai_start;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status_byte[5:4] == 2'b00);

  a_r11_verdict_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cmd_go && cmd_reject));

  a_r11_verdict_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    !mem_cmd |=> !cmd_go && !cmd_reject);

  a_r5_go_with_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> status_byte[0]);

  a_r3_wren_sets_wel: assert property (@(posedge clk) disable iff (rst)
    wren_cmd && !status_byte[0] |=> status_byte[1]);

  a_r6_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    status_byte[0] && any_cmd && !prog_done && !erase_done
    |=> !cmd_go && !cmd_reject && $stable(status_byte));

  a_r8_lock_holds_bp: assert property (@(posedge clk) disable iff (rst)
    status_byte[7] && wrsr_cmd |=> $stable(status_byte[3:2]));

  a_r10_end_of_array: assert property (@(posedge clk) disable iff (rst)
    status_byte[6] && status_byte[0] && prog_done && (prog_addr == ADDR_W'(ADDR_MAX))
    |=> !status_byte[1] && !status_byte[6]);

endmodule

bind flash_status_ctl fsc_checker #(
  .ADDR_MAX (ADDR_MAX),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wren_cmd    (wren_cmd),
  .wrdi_cmd    (wrdi_cmd),
  .wrsr_cmd    (wrsr_cmd),
  .prog_start  (prog_start),
  .prog_done   (prog_done),
  .erase_start (erase_start),
  .erase_done  (erase_done),
  .aai_start   (aai_start),
  .prog_addr   (prog_addr),
  .status_byte (status_byte),
  .cmd_go      (cmd_go),
  .cmd_reject  (cmd_reject)
);

// File: tb/flash_status_ctl_tb.sv
module flash_status_ctl_tb;

  localparam int unsigned AMAX = 32'h7FFFF;
  localparam int unsigned AW   = $clog2(AMAX + 1);

  // Opcodes used by the stimulus task
  localparam int OP_NONE = 0, OP_WREN = 1, OP_WRDI = 2, OP_WRSR = 3,
                 OP_PGM = 4, OP_ERS = 5, OP_AAI = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wren_cmd = 0, wrdi_cmd = 0, wrsr_cmd = 0;
  logic [7:0]    wrsr_data = '0;
  logic          prog_start = 0, prog_done = 0, erase_start = 0, erase_done = 0, aai_start = 0;
  logic [AW-1:0] prog_addr = '0;
  logic [7:0]    status_byte;
  logic          cmd_go, cmd_reject;

  always #2 clk = ~clk;

  flash_status_ctl #(.ADDR_MAX(AMAX)) u_dut (
    .clk(clk), .rst(rst),
    .wren_cmd(wren_cmd), .wrdi_cmd(wrdi_cmd), .wrsr_cmd(wrsr_cmd), .wrsr_data(wrsr_data),
    .prog_start(prog_start), .prog_done(prog_done),
    .erase_start(erase_start), .erase_done(erase_done),
    .aai_start(aai_start), .prog_addr(prog_addr),
    .status_byte(status_byte), .cmd_go(cmd_go), .cmd_reject(cmd_reject)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model state
  bit m_busy, m_wel, m_aai, m_lock, m_go, m_rej;
  bit [1:0] m_bp;

  function automatic logic [7:0] m_status();
    return {m_lock, m_aai, 2'b00, m_bp, m_wel, m_busy};
  endfunction

  task automatic check(input string req);
    checks++;
    if (status_byte !== m_status()) begin
      fails++;
      $display("FAIL %s status actual=%02h expected=%02h", req, status_byte, m_status());
    end
    checks++;
    if (cmd_go !== m_go || cmd_reject !== m_rej) begin
      fails++;
      $display("FAIL %s go/reject actual=%b%b expected=%b%b", req, cmd_go, cmd_reject, m_go, m_rej);
    end
    checks++;
    if (status_byte[5:4] !== 2'b00) begin // R2 reserved bits
      fails++;
      $display("FAIL R2 reserved actual=%b expected=00", status_byte[5:4]);
    end
  endtask

  task automatic model_reset();
    m_busy = 0; m_wel = 0; m_aai = 0; m_lock = 0; m_go = 0; m_rej = 0; m_bp = 2'b11;
  endtask

  // Called at a negedge; result is compared at the following negedge
  task automatic cyc(input int op, input logic [7:0] d, input logic pd, input logic ed,
                     input logic [AW-1:0] a, input string req);
    bit n_busy, n_wel, n_aai, n_lock, n_go, n_rej, endhit;
    bit [1:0] n_bp;
    wren_cmd = (op == OP_WREN); wrdi_cmd = (op == OP_WRDI); wrsr_cmd = (op == OP_WRSR);
    prog_start = (op == OP_PGM); erase_start = (op == OP_ERS); aai_start = (op == OP_AAI);
    wrsr_data = d; prog_done = pd; erase_done = ed; prog_addr = a;
    n_busy = m_busy; n_wel = m_wel; n_aai = m_aai; n_lock = m_lock; n_bp = m_bp;
    n_go = 0; n_rej = 0;
    if (!m_busy) begin
      case (op)
        OP_WREN: n_wel = 1;
        OP_WRDI: begin n_wel = 0; n_aai = 0; end
        OP_WRSR: if (m_wel) begin n_lock = d[7]; if (!m_lock) n_bp = d[3:2]; end
        OP_PGM:  if (m_wel) begin n_go = 1; n_busy = 1; end else n_rej = 1;
        OP_ERS:  if (m_wel && !m_aai) begin n_go = 1; n_busy = 1; end else n_rej = 1;
        OP_AAI:  if (m_wel && !m_aai) begin n_go = 1; n_busy = 1; n_aai = 1; end else n_rej = 1;
        default: ;
      endcase
    end else if (pd || ed) begin
      endhit = m_aai && (a == AW'(AMAX));
      n_busy = 0;
      if (!m_aai || endhit) n_wel = 0;
      if (endhit) n_aai = 0;
    end
    @(posedge clk);
    m_busy = n_busy; m_wel = n_wel; m_aai = n_aai; m_lock = n_lock; m_bp = n_bp;
    m_go = n_go; m_rej = n_rej;
    @(negedge clk);
    check(req);
    wren_cmd = 0; wrdi_cmd = 0; wrsr_cmd = 0; prog_start = 0; erase_start = 0;
    aai_start = 0; prog_done = 0; erase_done = 0;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(OP_NONE, 8'h00, 0, 0, '0, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1");
  endtask

  initial begin
    model_reset();
    do_reset();
    idle(2, "R1");

    // R5: memory writes rejected with the latch clear
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R5");
    cyc(OP_ERS, 8'h00, 0, 0, '0, "R5");
    cyc(OP_AAI, 8'h00, 0, 0, '0, "R5");
    // R8: status write ignored without the latch
    cyc(OP_WRSR, 8'h00, 0, 0, '0, "R8");

    // R3 then status writes (R8)
    cyc(OP_WREN, 8'h00, 0, 0, '0, "R3");
    cyc(OP_WRSR, 8'h00, 0, 0, '0, "R8");
    cyc(OP_WRSR, 8'hFF, 0, 0, '0, "R8");
    cyc(OP_WRSR, 8'h80, 0, 0, '0, "R8");
    cyc(OP_WRSR, 8'h00, 0, 0, '0, "R8");
    cyc(OP_WRSR, 8'h00, 0, 0, '0, "R8");
    cyc(OP_WRSR, 8'h4B, 0, 0, '0, "R8");

    // R5 go, R6 busy window, R7 completion
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R5");
    cyc(OP_WREN, 8'h00, 0, 0, '0, "R6");
    cyc(OP_WRDI, 8'h00, 0, 0, '0, "R6");
    cyc(OP_WRSR, 8'h8C, 0, 0, '0, "R6");
    cyc(OP_ERS, 8'h00, 0, 0, '0, "R6");
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R6");
    idle(3, "R6");
    cyc(OP_NONE, 8'h00, 1, 0, '0, "R7");
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R7");

    // Erase path
    cyc(OP_WREN, 8'h00, 0, 0, '0, "R3");
    cyc(OP_ERS, 8'h00, 0, 0, '0, "R5");
    idle(2, "R6");
    cyc(OP_NONE, 8'h00, 0, 1, '0, "R7");
    cyc(OP_NONE, 8'h00, 1, 1, '0, "R7");

    // Auto-increment sequence ended by write disable
    cyc(OP_WREN, 8'h00, 0, 0, '0, "R3");
    cyc(OP_AAI, 8'h00, 0, 0, '0, "R9");
    cyc(OP_NONE, 8'h00, 1, 0, AW'(0), "R7");
    cyc(OP_ERS, 8'h00, 0, 0, '0, "R9");
    cyc(OP_AAI, 8'h00, 0, 0, '0, "R9");
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R9");
    cyc(OP_NONE, 8'h00, 1, 0, AW'(5), "R9");
    cyc(OP_WRDI, 8'h00, 0, 0, '0, "R4");
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R4");

    // Auto-increment reaching the last address
    cyc(OP_WREN, 8'h00, 0, 0, '0, "R3");
    cyc(OP_AAI, 8'h00, 0, 0, '0, "R9");
    cyc(OP_NONE, 8'h00, 1, 0, AW'(AMAX - 1), "R9");
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R9");
    cyc(OP_NONE, 8'h00, 1, 0, AW'(AMAX), "R10");
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R10");

    // R4 plain write disable, R11 verdict only with a command
    cyc(OP_WREN, 8'h00, 0, 0, '0, "R3");
    cyc(OP_WRDI, 8'h00, 0, 0, '0, "R4");
    idle(2, "R11");

    // Reset in the middle of a modified state
    cyc(OP_WREN, 8'h00, 0, 0, '0, "R3");
    cyc(OP_WRSR, 8'h80, 0, 0, '0, "R8");
    cyc(OP_PGM, 8'h00, 0, 0, '0, "R5");
    do_reset();
    idle(1, "R1");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule